// File: doc/BRIEF.md
# Ethernet Header Field Extractor

This block parses a received Ethernet frame while it streams in, one byte per clock, and publishes the header fields that a reception handler needs to classify the frame without running a protocol stack. The byte stream starts with the first destination-address byte, after preamble and delimiter have been stripped. A qualifying valid line stays high for the whole frame.

A state machine follows the header. It branches on the EtherType into an IPv4 path and then into a UDP path. On the way it latches the EtherType, the IPv4 protocol number, the source and destination addresses, and the UDP ports. It also compares the destination address and destination port against programmable values. Flags report how far the parse got and whether the frame should go straight to the application. A one-cycle done pulse tells the handler that the frame has ended and that the register set is ready to read. The register set then holds until the next frame begins.

Top module: `eth_hdr_extract`

## Requirements
- R1: Frame bytes are numbered from 0, starting at the first byte with rx_valid_i high after an idle cycle. A frame is the unbroken run of valid bytes, and the first cycle with rx_valid_i low ends it.
- R2: etype_o holds bytes 12 and 13 of the frame, with byte 12 as the upper half. It is updated at the clock edge that takes byte 13.
- R3: An EtherType of 0x0800 sets is_ip_o. Any other EtherType leaves is_ip_o, is_udp_o and all IP and UDP fields at zero.
- R4: In an IPv4 frame, a byte 14 other than 0x45 stops the parse. is_ip_o stays set, while is_udp_o, ip_proto_o, the addresses and the ports stay zero.
- R5: In an IPv4 frame with byte 14 equal to 0x45, ip_proto_o takes byte 23, ip_src_o takes bytes 26–29 and ip_dst_o takes bytes 30–33. In each multi-byte field the first byte is the most significant.
- R6: A protocol of 17 makes udp_sport_o take bytes 34–35 and udp_dport_o take bytes 36–37, and sets is_udp_o at the edge that takes byte 37. Any other protocol leaves the ports and is_udp_o at zero.
- R7: ip_match_o is set when the complete IPv4 destination address equals match_ip_i. The comparison is made at the edge that takes byte 33.
- R8: port_match_o is set when a UDP frame's destination port equals match_port_i. deliver_o is high exactly when is_udp_o, ip_match_o and port_match_o are all high.
- R9: A frame that ends before the bytes a flag depends on have arrived leaves that flag clear.
- R10: done_o is high for exactly one cycle, the cycle after the edge that sees rx_valid_i low following a frame.
- R11: The edge that takes byte 0 of a frame clears every field and flag. Between frames all outputs hold their values.
- R12: After reset all fields, flags and done_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_byte_i | input | 8 | Received frame byte |
| rx_valid_i | input | 1 | Byte qualifier, high for the whole frame |
| match_ip_i | input | 32 | Destination address to compare against |
| match_port_i | input | 16 | UDP destination port to compare against |
| etype_o | output | 16 | Latched EtherType |
| ip_proto_o | output | 8 | Latched IPv4 protocol number |
| ip_src_o | output | 32 | Latched IPv4 source address |
| ip_dst_o | output | 32 | Latched IPv4 destination address |
| udp_sport_o | output | 16 | Latched UDP source port |
| udp_dport_o | output | 16 | Latched UDP destination port |
| is_ip_o | output | 1 | Frame is IPv4 |
| is_udp_o | output | 1 | Complete UDP port pair received |
| ip_match_o | output | 1 | Destination address matched |
| port_match_o | output | 1 | Destination port matched |
| deliver_o | output | 1 | Frame qualifies for direct delivery |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The end-of-frame pulse of one frame and the first byte of the next frame meet in the same cycle when the two frames are separated by a single idle cycle. A dedicated scenario sends two such frames. During the done cycle it checks that the previous frame's flags and addresses are still visible while byte 0 of the new frame sits on the input. One cycle later it checks that done_o has dropped and that the register set has been cleared.

// File: rtl/eth_hdr_pkg.sv
package eth_hdr_pkg;
  typedef enum logic [1:0] {
    PS_L2,
    PS_L3,
    PS_L4,
    PS_HALT
  } parse_st_e;

  localparam int unsigned ETYPE_HI_OFF = 12;
  localparam int unsigned ETYPE_LO_OFF = 13;
  localparam int unsigned VER_OFF      = 14;
  localparam int unsigned PROTO_OFF    = 23;
  localparam int unsigned SRC_FIRST    = 26;
  localparam int unsigned SRC_LAST     = 29;
  localparam int unsigned DST_FIRST    = 30;
  localparam int unsigned DST_LAST     = 33;
  localparam int unsigned SPORT_FIRST  = 34;
  localparam int unsigned SPORT_LAST   = 35;
  localparam int unsigned DPORT_FIRST  = 36;
  localparam int unsigned DPORT_LAST   = 37;

  localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
  localparam logic [7:0]  VER_IHL_STD  = 8'h45;
  localparam logic [7:0]  PROTO_UDP    = 8'd17;
endpackage

// File: rtl/eth_hdr_pos.sv
module eth_hdr_pos #(
  parameter int unsigned POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             sof_o,
  output logic [POS_W-1:0] pos_o,
  output logic             done_o
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic             in_frame_q;
  logic [POS_W-1:0] cnt_q;

  assign sof_o = valid_i & ~in_frame_q;
  assign pos_o = in_frame_q ? cnt_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      done_o     <= 1'b0;
    end else if (valid_i) begin
      in_frame_q <= 1'b1;
      cnt_q      <= (pos_o == POS_MAX) ? POS_MAX : pos_o + 1'b1;
      done_o     <= 1'b0;
    end else begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      done_o     <= in_frame_q;
    end
  end

  // R10: end pulse lasts one cycle
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R1: a frame start always takes index 0 and the next index is 1
  a_r1_index_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o && valid_i) |=> (!valid_i || pos_o == POS_W'(1)));
endmodule

// File: rtl/eth_hdr_fields.sv
module eth_hdr_fields
  import eth_hdr_pkg::*;
#(
  parameter int unsigned POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       byte_i,
  output logic [15:0]      etype_o,
  output logic [7:0]       proto_o,
  output logic [31:0]      src_o,
  output logic [31:0]      dst_o,
  output logic [15:0]      sport_o,
  output logic [15:0]      dport_o,
  output logic             is_ip_o,
  output logic             is_udp_o,
  output logic             dst_last_o,
  output logic [31:0]      dst_next_o,
  output logic             l4_last_o,
  output logic [15:0]      dport_next_o
);
  localparam logic [POS_W-1:0] P_ET_HI = POS_W'(ETYPE_HI_OFF);
  localparam logic [POS_W-1:0] P_ET_LO = POS_W'(ETYPE_LO_OFF);
  localparam logic [POS_W-1:0] P_VER   = POS_W'(VER_OFF);
  localparam logic [POS_W-1:0] P_PROTO = POS_W'(PROTO_OFF);
  localparam logic [POS_W-1:0] P_SRC0  = POS_W'(SRC_FIRST);
  localparam logic [POS_W-1:0] P_SRC3  = POS_W'(SRC_LAST);
  localparam logic [POS_W-1:0] P_DST0  = POS_W'(DST_FIRST);
  localparam logic [POS_W-1:0] P_DST3  = POS_W'(DST_LAST);
  localparam logic [POS_W-1:0] P_SP0   = POS_W'(SPORT_FIRST);
  localparam logic [POS_W-1:0] P_SP1   = POS_W'(SPORT_LAST);
  localparam logic [POS_W-1:0] P_DP0   = POS_W'(DPORT_FIRST);
  localparam logic [POS_W-1:0] P_DP1   = POS_W'(DPORT_LAST);

  parse_st_e   st_q;
  logic        take;
  logic [15:0] etype_next;

  assign take         = valid_i & ~sof_i;
  assign etype_next   = {etype_o[7:0], byte_i};
  assign dst_next_o   = {dst_o[23:0], byte_i};
  assign dport_next_o = {dport_o[7:0], byte_i};
  assign dst_last_o   = take && st_q == PS_L3 && pos_i == P_DST3;
  assign l4_last_o    = take && st_q == PS_L4 && pos_i == P_DP1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= PS_L2;
      etype_o  <= '0;
      proto_o  <= '0;
      src_o    <= '0;
      dst_o    <= '0;
      sport_o  <= '0;
      dport_o  <= '0;
      is_ip_o  <= 1'b0;
      is_udp_o <= 1'b0;
    end else if (sof_i) begin
      st_q     <= PS_L2;
      etype_o  <= '0;
      proto_o  <= '0;
      src_o    <= '0;
      dst_o    <= '0;
      sport_o  <= '0;
      dport_o  <= '0;
      is_ip_o  <= 1'b0;
      is_udp_o <= 1'b0;
    end else if (take) begin
      unique case (st_q)
        PS_L2: begin
          if (pos_i == P_ET_HI || pos_i == P_ET_LO) etype_o <= etype_next;
          if (pos_i == P_ET_LO) begin
            if (etype_next == ETYPE_IPV4) begin
              is_ip_o <= 1'b1;
              st_q    <= PS_L3;
            end else begin
              st_q <= PS_HALT;
            end
          end
        end
        PS_L3: begin
          if (pos_i == P_VER && byte_i != VER_IHL_STD) st_q <= PS_HALT;
          if (pos_i == P_PROTO) proto_o <= byte_i;
          if (pos_i >= P_SRC0 && pos_i <= P_SRC3) src_o <= {src_o[23:0], byte_i};
          if (pos_i >= P_DST0 && pos_i <= P_DST3) dst_o <= dst_next_o;
          if (pos_i == P_DST3) st_q <= (proto_o == PROTO_UDP) ? PS_L4 : PS_HALT;
        end
        PS_L4: begin
          if (pos_i >= P_SP0 && pos_i <= P_SP1) sport_o <= {sport_o[7:0], byte_i};
          if (pos_i >= P_DP0 && pos_i <= P_DP1) dport_o <= dport_next_o;
          if (pos_i == P_DP1) begin
            is_udp_o <= 1'b1;
            st_q     <= PS_HALT;
          end
        end
        default: ;
      endcase
    end
  end

  // R6: a UDP frame is always an IPv4 frame
  a_r6_udp_needs_ip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_udp_o |-> is_ip_o);

  // R3: the IPv4 flag only ever stands beside the IPv4 EtherType
  a_r3_ip_etype: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ip_o |-> etype_o == ETYPE_IPV4);

  // R11: a frame start wipes the register set
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (!is_ip_o && !is_udp_o && etype_o == '0 && src_o == '0 && dport_o == '0));
endmodule

// File: rtl/eth_hdr_match.sv
module eth_hdr_match (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sof_i,
  input  logic        dst_last_i,
  input  logic [31:0] dst_next_i,
  input  logic [31:0] match_ip_i,
  input  logic        l4_last_i,
  input  logic [15:0] dport_next_i,
  input  logic [15:0] match_port_i,
  output logic        ip_hit_o,
  output logic        port_hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_hit_o   <= 1'b0;
      port_hit_o <= 1'b0;
    end else if (sof_i) begin
      ip_hit_o   <= 1'b0;
      port_hit_o <= 1'b0;
    end else begin
      if (dst_last_i) ip_hit_o   <= (dst_next_i == match_ip_i);
      if (l4_last_i)  port_hit_o <= (dport_next_i == match_port_i);
    end
  end

  // R11: hits drop at every frame start
  a_r11_hits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (!ip_hit_o && !port_hit_o));
endmodule

// File: rtl/eth_hdr_extract.sv
module eth_hdr_extract #(
  parameter int unsigned POS_W = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_valid_i,
  input  logic [31:0] match_ip_i,
  input  logic [15:0] match_port_i,
  output logic [15:0] etype_o,
  output logic [7:0]  ip_proto_o,
  output logic [31:0] ip_src_o,
  output logic [31:0] ip_dst_o,
  output logic [15:0] udp_sport_o,
  output logic [15:0] udp_dport_o,
  output logic        is_ip_o,
  output logic        is_udp_o,
  output logic        ip_match_o,
  output logic        port_match_o,
  output logic        deliver_o,
  output logic        done_o
);
  logic             sof;
  logic [POS_W-1:0] pos;
  logic             dst_last;
  logic             l4_last;
  logic [31:0]      dst_next;
  logic [15:0]      dport_next;

  eth_hdr_pos #(.POS_W(POS_W)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rx_valid_i),
    .sof_o  (sof),
    .pos_o  (pos),
    .done_o (done_o)
  );

  eth_hdr_fields #(.POS_W(POS_W)) u_fields (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (rx_valid_i),
    .sof_i       (sof),
    .pos_i       (pos),
    .byte_i      (rx_byte_i),
    .etype_o     (etype_o),
    .proto_o     (ip_proto_o),
    .src_o       (ip_src_o),
    .dst_o       (ip_dst_o),
    .sport_o     (udp_sport_o),
    .dport_o     (udp_dport_o),
    .is_ip_o     (is_ip_o),
    .is_udp_o    (is_udp_o),
    .dst_last_o  (dst_last),
    .dst_next_o  (dst_next),
    .l4_last_o   (l4_last),
    .dport_next_o(dport_next)
  );

  eth_hdr_match u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof),
    .dst_last_i  (dst_last),
    .dst_next_i  (dst_next),
    .match_ip_i  (match_ip_i),
    .l4_last_i   (l4_last),
    .dport_next_i(dport_next),
    .match_port_i(match_port_i),
    .ip_hit_o    (ip_match_o),
    .port_hit_o  (port_match_o)
  );

  assign deliver_o = is_udp_o & ip_match_o & port_match_o;

  // R8: a port hit is only possible on a UDP frame
  a_r8_port_needs_udp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_match_o |-> is_udp_o);

  // R7: an address hit needs an IPv4 frame
  a_r7_ip_hit_needs_ip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_match_o |-> is_ip_o);

  // R11: outputs hold while no byte is taken
  a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> ($stable(ip_dst_o) && $stable(is_udp_o) && $stable(etype_o)));
endmodule

// File: tb/tb_eth_hdr_extract.sv
module tb_eth_hdr_extract;
  logic        clk;
  logic        rst_n;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic [31:0] match_ip;
  logic [15:0] match_port;
  logic [15:0] etype;
  logic [7:0]  ip_proto;
  logic [31:0] ip_src;
  logic [31:0] ip_dst;
  logic [15:0] udp_sport;
  logic [15:0] udp_dport;
  logic        is_ip;
  logic        is_udp;
  logic        ip_match;
  logic        port_match;
  logic        deliver;
  logic        done;

  int checks = 0;
  int fails  = 0;
  logic [7:0] frm [0:63];

  localparam logic [31:0] SRC_A = 32'h0A00_0001;
  localparam logic [31:0] DST_A = 32'hC0A8_0A05;
  localparam logic [15:0] SP_A  = 16'hC350;
  localparam logic [15:0] DP_A  = 16'h1F90;

  eth_hdr_extract dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_byte_i   (rx_byte),
    .rx_valid_i  (rx_valid),
    .match_ip_i  (match_ip),
    .match_port_i(match_port),
    .etype_o     (etype),
    .ip_proto_o  (ip_proto),
    .ip_src_o    (ip_src),
    .ip_dst_o    (ip_dst),
    .udp_sport_o (udp_sport),
    .udp_dport_o (udp_dport),
    .is_ip_o     (is_ip),
    .is_udp_o    (is_udp),
    .ip_match_o  (ip_match),
    .port_match_o(port_match),
    .deliver_o   (deliver),
    .done_o      (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] et, input logic [7:0] ver,
                       input logic [7:0] proto, input logic [31:0] src,
                       input logic [31:0] dst, input logic [15:0] sp,
                       input logic [15:0] dp);
    for (int i = 0; i < 64; i++) frm[i] = 8'(i * 7 + 3);
    frm[12] = et[15:8];   frm[13] = et[7:0];
    frm[14] = ver;        frm[23] = proto;
    frm[26] = src[31:24]; frm[27] = src[23:16]; frm[28] = src[15:8]; frm[29] = src[7:0];
    frm[30] = dst[31:24]; frm[31] = dst[23:16]; frm[32] = dst[15:8]; frm[33] = dst[7:0];
    frm[34] = sp[15:8];   frm[35] = sp[7:0];
    frm[36] = dp[15:8];   frm[37] = dp[7:0];
  endtask

  // drives len bytes, then drops valid; returns at the negedge valid fell
  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = frm[i];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
  endtask

  task automatic t_reset;
    chk("R12", "etype", 32'(etype), 32'h0);
    chk("R12", "flags", {26'b0, is_ip, is_udp, ip_match, port_match, deliver, done}, 32'h0);
    chk("R12", "ip_src", ip_src, 32'h0);
  endtask

  task automatic t_udp_hit;
    build(16'h0800, 8'h45, 8'd17, SRC_A, DST_A, SP_A, DP_A);
    send(50);
    @(negedge clk);
    chk("R10", "done pulse", 32'(done), 32'h1);
    chk("R2", "etype", 32'(etype), 32'h0800);
    chk("R3", "is_ip", 32'(is_ip), 32'h1);
    chk("R5", "proto", 32'(ip_proto), 32'd17);
    chk("R5", "src", ip_src, SRC_A);
    chk("R5", "dst", ip_dst, DST_A);
    chk("R6", "sport", 32'(udp_sport), 32'(SP_A));
    chk("R6", "dport", 32'(udp_dport), 32'(DP_A));
    chk("R6", "is_udp", 32'(is_udp), 32'h1);
    chk("R7", "ip_match", 32'(ip_match), 32'h1);
    chk("R8", "deliver", {30'b0, port_match, deliver}, 32'h3);
    @(negedge clk);
    chk("R10", "done single", 32'(done), 32'h0);
    chk("R11", "hold dst", ip_dst, DST_A);
  endtask

  task automatic t_port_miss;
    build(16'h0800, 8'h45, 8'd17, SRC_A, DST_A, SP_A, 16'h1F91);
    send(46);
    @(negedge clk);
    chk("R8", "port miss", {29'b0, ip_match, port_match, deliver}, 32'h4);
    chk("R6", "dport", 32'(udp_dport), 32'h1F91);
  endtask

  task automatic t_ip_miss;
    build(16'h0800, 8'h45, 8'd17, SRC_A, 32'hC0A8_0A06, SP_A, DP_A);
    send(46);
    @(negedge clk);
    chk("R7", "ip miss", {29'b0, ip_match, port_match, deliver}, 32'h2);
  endtask

  task automatic t_non_ip;
    build(16'h86DD, 8'h45, 8'd17, SRC_A, DST_A, SP_A, DP_A);
    send(46);
    @(negedge clk);
    chk("R2", "etype other", 32'(etype), 32'h86DD);
    chk("R3", "non-ip flags", {28'b0, is_ip, is_udp, ip_match, deliver}, 32'h0);
    chk("R3", "non-ip src", ip_src, 32'h0);
    chk("R3", "non-ip dport", 32'(udp_dport), 32'h0);
  endtask

  task automatic t_bad_ver;
    build(16'h0800, 8'h46, 8'd17, SRC_A, DST_A, SP_A, DP_A);
    send(46);
    @(negedge clk);
    chk("R4", "bad ver is_ip", 32'(is_ip), 32'h1);
    chk("R4", "bad ver is_udp", 32'(is_udp), 32'h0);
    chk("R4", "bad ver proto", 32'(ip_proto), 32'h0);
    chk("R4", "bad ver addr", ip_src | ip_dst, 32'h0);
    chk("R4", "bad ver port", 32'(udp_sport), 32'h0);
  endtask

  task automatic t_tcp;
    build(16'h0800, 8'h45, 8'd6, SRC_A, DST_A, SP_A, DP_A);
    send(46);
    @(negedge clk);
    chk("R6", "tcp is_udp", 32'(is_udp), 32'h0);
    chk("R6", "tcp ports", {udp_sport, udp_dport}, 32'h0);
    chk("R5", "tcp dst", ip_dst, DST_A);
    chk("R7", "tcp ip_match", 32'(ip_match), 32'h1);
    chk("R8", "tcp deliver", {30'b0, port_match, deliver}, 32'h0);
  endtask

  task automatic t_trunc;
    build(16'h0800, 8'h45, 8'd17, SRC_A, DST_A, SP_A, DP_A);
    send(30);
    @(negedge clk);
    chk("R10", "trunc done", 32'(done), 32'h1);
    chk("R9", "trunc is_ip", 32'(is_ip), 32'h1);
    chk("R9", "trunc src", ip_src, SRC_A);
    chk("R9", "trunc flags", {29'b0, is_udp, ip_match, deliver}, 32'h0);
  endtask

  task automatic t_back_to_back;
    build(16'h0800, 8'h45, 8'd17, SRC_A, DST_A, SP_A, DP_A);
    send(42);
    @(negedge clk);
    chk("R10", "b2b done", 32'(done), 32'h1);
    chk("R11", "b2b old kept", {31'b0, deliver}, 32'h1);
    build(16'h0800, 8'h45, 8'd6, 32'h0B0B_0B0B, 32'h0C0C_0C0C, SP_A, DP_A);
    rx_valid = 1'b1;
    rx_byte  = frm[0];
    @(negedge clk);
    chk("R11", "b2b done low", 32'(done), 32'h0);
    chk("R11", "b2b cleared", {28'b0, is_ip, is_udp, ip_match, port_match}, 32'h0);
    chk("R11", "b2b src cleared", ip_src, 32'h0);
    chk("R1", "b2b etype cleared", 32'(etype), 32'h0);
    for (int i = 1; i < 46; i++) begin
      rx_byte = frm[i];
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
    @(negedge clk);
    chk("R1", "b2b second src", ip_src, 32'h0B0B_0B0B);
    chk("R7", "b2b second miss", 32'(ip_match), 32'h0);
  endtask

  initial begin
    rst_n      = 1'b0;
    rx_valid   = 1'b0;
    rx_byte    = 8'h00;
    match_ip   = DST_A;
    match_port = DP_A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_udp_hit();
    t_port_miss();
    t_ip_miss();
    t_non_ip();
    t_bad_ver();
    t_tcp();
    t_trunc();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule